// File: doc/BRIEF.md
# SWD Host Identification Reader

This block is a two-wire Serial Wire Debug host. It drives the debug clock and the bidirectional data pad of a target debug port. A single `start` pulse brings the port into SWD mode and reads its identification word. The block first drives a line reset with data high. It then sends the 16-bit JTAG-to-SWD switch pattern, a second line reset, and a short run of low idle bits. After that it sends the 8-bit read request for the identification register and hands the data line to the target for one turnaround bit. It samples a 3-bit acknowledge and, when that acknowledge is OK, 32 data bits and their parity. It then takes the line back and finishes with one high-data clock and a few trailing idle pulses.

The bit rate comes from the `clk_div` input. Every bit lasts 2*(clk_div+1) system clocks: a low half followed by a high half. The clock idles high. The host changes the data line only on a falling clock edge. It samples `swdio_i` in the system cycle in which the clock rises, so a target must present its bit while the clock is low. Between transactions the clock, the data line and the output enable all stay high. A target that shares its reset input with the data pin therefore never sees a long low level.

The sequencer has thirteen states:
- IDLE goes to LRST_A when `start` is seen.
- LRST_A goes to SELECT after LINE_RESET_CYCLES bits.
- SELECT goes to LRST_B after 16 bits.
- LRST_B goes to LEAD_IDLE after LINE_RESET_CYCLES bits.
- LEAD_IDLE goes to REQUEST after LEAD_IDLE_CYCLES bits.
- REQUEST goes to TURN_IN after 8 bits.
- TURN_IN goes to ACK after 1 bit.
- ACK goes to DATA when the acknowledge is OK. On any other acknowledge it goes to TURN_OUT.
- DATA goes to PARITY after 32 bits.
- PARITY goes to TURN_OUT after 1 bit.
- TURN_OUT goes to TAIL_HIGH after 1 bit.
- TAIL_HIGH goes to TAIL_IDLE after 1 bit.
- TAIL_IDLE goes back to IDLE after TAIL_IDLE_CYCLES bits and pulses `done`.

Top module: `swd_idcode_host`

## Requirements
- R1: While idle and while reset is held, `swclk_o`, `swdio_o` and `swdio_oe` are 1 and `busy` is 0.
- R2: A transaction opens with LINE_RESET_CYCLES (default 50) bits of data 1 with the output enabled. A second run of the same length follows the switch pattern.
- R3: Between the two line resets the host sends 16'hE79E, bit 0 first.
- R4: After the second line reset the host sends LEAD_IDLE_CYCLES bits of data 0, then the request byte 8'hA5, bit 0 first.
- R5: `swdio_oe` is 0 for the turnaround bit after the request and through every bit the target drives. It stays 0 through the one turnaround bit back, and is 1 for every other bit.
- R6: The acknowledge is taken in the order received, with the first bit in `ack[0]`. OK is 3'b001. On OK, 32 data bits are received bit 0 first and then one parity bit. `idcode` takes the word, and `parity_ok` is 1 only when the parity bit equals the XOR of the 32 data bits.
- R7: Any acknowledge other than 3'b001 skips the data and parity bits. The turnaround back follows the acknowledge at once. The block sets `fail` to 1 and `parity_ok` to 0, and leaves `idcode` unchanged.
- R8: A received word of all ones sets `fail` to 1 and `parity_ok` to 0, and leaves `idcode` unchanged.
- R9: After the turnaround back the host sends one bit of data 1, then TAIL_IDLE_CYCLES bits of data 0. It then stops with the clock and data high. A full read has 167 bits and a failed acknowledge has 134, with the default parameters.
- R10: Within a transaction every clock period is exactly 2*(clk_div+1) system cycles. `swdio_o` and `swdio_oe` change only on a falling clock edge, or on the return to idle.
- R11: `busy` rises in the cycle after `start` is taken in IDLE and stays high until the end. `done` is a one-cycle pulse in the cycle `busy` falls. `fail` and `parity_ok` are cleared when a transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-bit length minus one, in system cycles |
| start | input | 1 | Begin a transaction when idle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| fail | output | 1 | Last transaction had a bad acknowledge or an all-ones word |
| ack | output | 3 | Last received acknowledge, first bit in bit 0 |
| idcode | output | 32 | Last identification word captured |
| parity_ok | output | 1 | Parity of the last captured word matched |
| swclk_o | output | 1 | Debug clock pad |
| swdio_o | output | 1 | Data pad output value |
| swdio_i | input | 1 | Data pad input value |
| swdio_oe | output | 1 | Data pad output enable |

## Verification
The hardest situation to reach from the ports is a target that answers at the right bit at the right time. The acknowledge and data bits must arrive about 127 bits into the transaction, aligned to the low half of each clock. The bench contains a small target model that counts falling edges of `swclk_o` and places each acknowledge, data and parity bit on `swdio_i` at its index. A table of vectors then covers:
- an OK read,
- a read with a corrupted parity bit,
- WAIT, FAULT and no-target acknowledges,
- an all-ones word,
- a zero word.

Directed tests cover a slower divider, the idle levels after a transaction, and reset asserted in the middle of a transaction.

// File: rtl/swd_host_pkg.sv
`timescale 1ns/1ps
package swd_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LRST_A,
        ST_SELECT,
        ST_LRST_B,
        ST_LEAD_IDLE,
        ST_REQUEST,
        ST_TURN_IN,
        ST_ACK,
        ST_DATA,
        ST_PARITY,
        ST_TURN_OUT,
        ST_TAIL_HIGH,
        ST_TAIL_IDLE
    } swd_state_e;

    localparam int SEL_BITS  = 16;
    localparam int REQ_BITS  = 8;
    localparam int ACK_BITS  = 3;
    localparam int WORD_BITS = 32;

    // Switch pattern and identification read request, both sent bit 0 first.
    localparam logic [SEL_BITS-1:0] SEL_PATTERN = 16'hE79E;
    localparam logic [REQ_BITS-1:0] REQ_IDREAD  = 8'hA5;
    localparam logic [ACK_BITS-1:0] ACK_OK      = 3'b001;

endpackage

// File: rtl/swd_bitclk.sv
`timescale 1ns/1ps
// Bit clock engine. Each bit is a low half and then a high half, each div+1
// cycles long. ready marks the last cycle of a high half. Asserting go in
// that cycle starts the next bit with no gap.
module swd_bitclk #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             go,
    output logic             swclk,
    output logic             ready,
    output logic             rise
);

    logic [DIV_W-1:0] cnt_q;
    logic             clk_q;
    logic             hi_full_q;
    logic             at_end;

    assign at_end = (cnt_q >= div);
    assign ready  = clk_q && (hi_full_q || at_end);
    assign rise   = !clk_q && at_end;
    assign swclk  = clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q     <= 1'b1;
            cnt_q     <= '0;
            hi_full_q <= 1'b1;
        end else if (clk_q) begin
            if (go && ready) begin
                clk_q     <= 1'b0;
                cnt_q     <= '0;
                hi_full_q <= 1'b0;
            end else if (!hi_full_q) begin
                if (at_end) begin
                    hi_full_q <= 1'b1;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else begin
            if (at_end) begin
                clk_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/swd_rx_shift.sv
`timescale 1ns/1ps
// Receive shifter. The first bit shifted in ends up in bit 0.
module swd_rx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= {din, q[W-1:1]};
        end
    end

endmodule

// File: rtl/swd_idcode_host.sv
`timescale 1ns/1ps
module swd_idcode_host
    import swd_host_pkg::*;
#(
    parameter int DIV_W             = 16,
    parameter int LINE_RESET_CYCLES = 50,
    parameter int LEAD_IDLE_CYCLES  = 2,
    parameter int TAIL_IDLE_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [2:0]       ack,
    output logic [31:0]      idcode,
    output logic             parity_ok,
    output logic             swclk_o,
    output logic             swdio_o,
    input  logic             swdio_i,
    output logic             swdio_oe
);

    localparam int MAX_A  = (LINE_RESET_CYCLES > WORD_BITS) ? LINE_RESET_CYCLES : WORD_BITS;
    localparam int MAX_B  = (LEAD_IDLE_CYCLES > TAIL_IDLE_CYCLES) ? LEAD_IDLE_CYCLES : TAIL_IDLE_CYCLES;
    localparam int MAXC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(LINE_RESET_CYCLES - 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_IDLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_IDLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SEL_BITS - 1);
    localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(REQ_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_BITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BITS - 1);

    swd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
    logic             dout_q, dout_d;
    logic             oe_q, oe_d;
    logic             done_q, fail_q, pok_q, par_q;
    logic [31:0]      id_q;

    logic             go, ready, rise;
    logic             take_start, ack_fail, word_end, finish;
    logic [ACK_BITS-1:0]  ack_sr;
    logic [WORD_BITS-1:0] word_sr;

    swd_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_div),
        .go    (go),
        .swclk (swclk_o),
        .ready (ready),
        .rise  (rise)
    );

    swd_rx_shift #(.W(ACK_BITS)) u_ack_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rise && (state_q == ST_ACK)),
        .din   (swdio_i),
        .q     (ack_sr)
    );

    swd_rx_shift #(.W(WORD_BITS)) u_word_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rise && (state_q == ST_DATA)),
        .din   (swdio_i),
        .q     (word_sr)
    );

    assign nxt = cnt_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and next bit: decided at the end of each high half
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        dout_d     = dout_q;
        oe_d       = oe_q;
        go         = 1'b0;
        take_start = 1'b0;
        ack_fail   = 1'b0;
        word_end   = 1'b0;
        finish     = 1'b0;
        if (ready) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        take_start = 1'b1;
                        go         = 1'b1;
                        state_d    = ST_LRST_A;
                        cnt_d      = '0;
                        dout_d     = 1'b1;
                        oe_d       = 1'b1;
                    end
                end
                ST_LRST_A: begin
                    go = 1'b1;
                    if (cnt_q == RST_LAST) begin
                        state_d = ST_SELECT;
                        cnt_d   = '0;
                        dout_d  = SEL_PATTERN[0];
                    end else begin
                        cnt_d  = nxt;
                        dout_d = 1'b1;
                    end
                end
                ST_SELECT: begin
                    go = 1'b1;
                    if (cnt_q == SEL_LAST) begin
                        state_d = ST_LRST_B;
                        cnt_d   = '0;
                        dout_d  = 1'b1;
                    end else begin
                        cnt_d  = nxt;
                        dout_d = SEL_PATTERN[nxt[3:0]];
                    end
                end
                ST_LRST_B: begin
                    go = 1'b1;
                    if (cnt_q == RST_LAST) begin
                        state_d = ST_LEAD_IDLE;
                        cnt_d   = '0;
                        dout_d  = 1'b0;
                    end else begin
                        cnt_d  = nxt;
                        dout_d = 1'b1;
                    end
                end
                ST_LEAD_IDLE: begin
                    go = 1'b1;
                    if (cnt_q == LEAD_LAST) begin
                        state_d = ST_REQUEST;
                        cnt_d   = '0;
                        dout_d  = REQ_IDREAD[0];
                    end else begin
                        cnt_d  = nxt;
                        dout_d = 1'b0;
                    end
                end
                ST_REQUEST: begin
                    go = 1'b1;
                    if (cnt_q == REQ_LAST) begin
                        state_d = ST_TURN_IN;
                        cnt_d   = '0;
                        dout_d  = 1'b1;
                        oe_d    = 1'b0;
                    end else begin
                        cnt_d  = nxt;
                        dout_d = REQ_IDREAD[nxt[2:0]];
                    end
                end
                ST_TURN_IN: begin
                    go      = 1'b1;
                    state_d = ST_ACK;
                    cnt_d   = '0;
                end
                ST_ACK: begin
                    go = 1'b1;
                    if (cnt_q == ACK_LAST) begin
                        cnt_d = '0;
                        if (ack_sr == ACK_OK) begin
                            state_d = ST_DATA;
                        end else begin
                            state_d  = ST_TURN_OUT;
                            ack_fail = 1'b1;
                        end
                    end else begin
                        cnt_d = nxt;
                    end
                end
                ST_DATA: begin
                    go = 1'b1;
                    if (cnt_q == WORD_LAST) begin
                        state_d = ST_PARITY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = nxt;
                    end
                end
                ST_PARITY: begin
                    go       = 1'b1;
                    word_end = 1'b1;
                    state_d  = ST_TURN_OUT;
                end
                ST_TURN_OUT: begin
                    go      = 1'b1;
                    state_d = ST_TAIL_HIGH;
                    dout_d  = 1'b1;
                    oe_d    = 1'b1;
                end
                ST_TAIL_HIGH: begin
                    go      = 1'b1;
                    state_d = ST_TAIL_IDLE;
                    cnt_d   = '0;
                    dout_d  = 1'b0;
                end
                ST_TAIL_IDLE: begin
                    if (cnt_q == TAIL_LAST) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        dout_d  = 1'b1;
                    end else begin
                        go     = 1'b1;
                        cnt_d  = nxt;
                        dout_d = 1'b0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    dout_d  = 1'b1;
                    oe_d    = 1'b1;
                end
            endcase
        end
    end

    // Outputs and captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b1;
            oe_q   <= 1'b1;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            pok_q  <= 1'b0;
            par_q  <= 1'b0;
            id_q   <= '0;
        end else begin
            dout_q <= dout_d;
            oe_q   <= oe_d;
            done_q <= finish;
            if (rise && (state_q == ST_PARITY)) begin
                par_q <= swdio_i;
            end
            if (take_start) begin
                fail_q <= 1'b0;
                pok_q  <= 1'b0;
            end
            if (ack_fail) begin
                fail_q <= 1'b1;
                pok_q  <= 1'b0;
            end
            if (word_end) begin
                if (&word_sr) begin
                    fail_q <= 1'b1;
                    pok_q  <= 1'b0;
                end else begin
                    id_q  <= word_sr;
                    pok_q <= ((^word_sr) == par_q);
                end
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign ack       = ack_sr;
    assign idcode    = id_q;
    assign parity_ok = pok_q;
    assign swdio_o   = dout_q;
    assign swdio_oe  = oe_q;

endmodule

module swd_idcode_host_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic parity_ok,
    input logic swclk_o,
    input logic swdio_o,
    input logic swdio_oe
);

    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk_o && swdio_o && swdio_oe));

    p_fall_in_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swclk_o) |-> busy);

    p_data_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swdio_o) |-> ($fell(swclk_o) || !busy));

    p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swdio_oe) |-> $fell(swclk_o));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_fail_no_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !parity_ok);

endmodule

bind swd_idcode_host swd_idcode_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .parity_ok (parity_ok),
    .swclk_o   (swclk_o),
    .swdio_o   (swdio_o),
    .swdio_oe  (swdio_oe)
);

// File: tb/tb_swd_idcode_host.sv
`timescale 1ns/1ps
module tb_swd_idcode_host;

    localparam int DIV_W  = 8;
    localparam int RST_N  = 50;
    localparam int LEAD_N = 2;
    localparam int TAIL_N = 2;
    localparam int B_SEL  = RST_N;
    localparam int B_R2   = B_SEL + 16;
    localparam int B_LEAD = B_R2 + RST_N;
    localparam int B_REQ  = B_LEAD + LEAD_N;
    localparam int B_TRN  = B_REQ + 8;
    localparam int B_ACK  = B_TRN + 1;
    localparam logic [15:0] SEL_PAT = 16'hE79E;
    localparam logic [7:0]  REQ_PAT = 8'hA5;

    // vector: ack[35:33], word[32:1], parity flip[0]
    localparam int NVEC = 7;
    localparam logic [35:0] VEC [NVEC] = '{
        {3'b001, 32'h0BB11477, 1'b0},
        {3'b001, 32'h1BA01477, 1'b1},
        {3'b010, 32'h12345678, 1'b0},
        {3'b001, 32'hFFFFFFFF, 1'b0},
        {3'b100, 32'hCAFEF00D, 1'b0},
        {3'b111, 32'hFFFFFFFF, 1'b1},
        {3'b001, 32'h00000000, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] clk_div = 8'd1;
    logic             swdio_i = 1'b1;
    logic             busy, done, fail, parity_ok, swclk_o, swdio_o, swdio_oe;
    logic [2:0]       ack;
    logic [31:0]      idcode;

    always #10 clk = ~clk;

    swd_idcode_host #(
        .DIV_W(DIV_W), .LINE_RESET_CYCLES(RST_N),
        .LEAD_IDLE_CYCLES(LEAD_N), .TAIL_IDLE_CYCLES(TAIL_N)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
        .busy(busy), .done(done), .fail(fail), .ack(ack), .idcode(idcode),
        .parity_ok(parity_ok), .swclk_o(swclk_o), .swdio_o(swdio_o),
        .swdio_i(swdio_i), .swdio_oe(swdio_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    // Target model: counts clock falls and drives its bits while the clock is low
    logic [2:0]  m_ack = 3'b111;
    logic [31:0] m_word = '1;
    logic        m_par = 1'b1;
    int          nfall = 0;
    int          period_err = 0;
    int          exp_period = 80;
    time         last_fall = 0;
    logic        hb [256];
    logic        ho [256];

    always @(negedge swclk_o) begin
        if (nfall >= B_ACK && nfall < B_ACK + 3)
            swdio_i = m_ack[nfall - B_ACK];
        else if (nfall >= B_ACK + 3 && nfall < B_ACK + 35)
            swdio_i = m_word[nfall - B_ACK - 3];
        else if (nfall == B_ACK + 35)
            swdio_i = m_par;
        else
            swdio_i = 1'b1;
        if (nfall > 0 && ($time - last_fall) != exp_period) period_err++;
        last_fall = $time;
        nfall++;
    end

    always @(posedge swclk_o) begin
        if (nfall > 0 && nfall <= 256) begin
            hb[nfall-1] = swdio_o;
            ho[nfall-1] = swdio_oe;
        end
    end

    task automatic check_wire(input bit ok_path);
        int e;
        int last;
        e = 0;
        for (int k = 0; k < RST_N; k++) begin
            if (hb[k] !== 1'b1 || ho[k] !== 1'b1) e++;
            if (hb[B_R2+k] !== 1'b1 || ho[B_R2+k] !== 1'b1) e++;
        end
        check(e == 0, "R2 line reset bits wrong", 32'(e), 0);
        e = 0;
        for (int k = 0; k < 16; k++) if (hb[B_SEL+k] !== SEL_PAT[k] || ho[B_SEL+k] !== 1'b1) e++;
        check(e == 0, "R3 switch pattern bits wrong", 32'(e), 0);
        e = 0;
        for (int k = 0; k < LEAD_N; k++) if (hb[B_LEAD+k] !== 1'b0) e++;
        for (int k = 0; k < 8; k++) if (hb[B_REQ+k] !== REQ_PAT[k] || ho[B_REQ+k] !== 1'b1) e++;
        check(e == 0, "R4 lead idle or request bits wrong", 32'(e), 0);
        last = ok_path ? (B_ACK + 36) : (B_ACK + 3);
        e = 0;
        for (int k = B_TRN; k <= last; k++) if (ho[k] !== 1'b0) e++;
        check(e == 0, "R5 output enable not released over target bits", 32'(e), 0);
        e = 0;
        if (hb[last+1] !== 1'b1 || ho[last+1] !== 1'b1) e++;
        for (int k = 0; k < TAIL_N; k++) if (hb[last+2+k] !== 1'b0 || ho[last+2+k] !== 1'b1) e++;
        check(e == 0, "R9 tail bits wrong", 32'(e), 0);
        check(nfall == last + 2 + TAIL_N, "R9 total bit count", 32'(nfall), 32'(last + 2 + TAIL_N));
    endtask

    task automatic run_tx(input logic [2:0] a, input logic [31:0] w, input logic pf);
        int t;
        bit seen;
        m_ack = a; m_word = w; m_par = (^w) ^ pf;
        nfall = 0; period_err = 0;
        exp_period = 2 * (int'(clk_div) + 1) * 20;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b1, "R11 busy after start", 32'(busy), 1);
        check(fail === 1'b0 && parity_ok === 1'b0, "R11 flags cleared at start",
              {30'd0, fail, parity_ok}, 0);
        t = 0; seen = 0;
        while (!seen && t < 20000) begin
            @(negedge clk);
            t++;
            if (done) seen = 1;
        end
        check(seen, "R11 done pulse seen", 32'(seen), 1);
        check(busy === 1'b0, "R11 busy low with done", 32'(busy), 0);
        @(negedge clk);
        check(done === 1'b0, "R11 done lasts one cycle", 32'(done), 0);
        check(period_err == 0, "R10 clock period mismatches", 32'(period_err), 0);
        repeat (3) @(negedge clk);
        check(swclk_o === 1'b1 && swdio_o === 1'b1 && swdio_oe === 1'b1,
              "R9 clock and data high after tail", {29'd0, swclk_o, swdio_o, swdio_oe}, 32'h7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_id;
        logic        ok_ack, ones, exp_fail;
        exp_id = '0;
        repeat (3) @(negedge clk);
        check(swclk_o === 1'b1 && swdio_o === 1'b1 && swdio_oe === 1'b1,
              "R1 levels during reset", {29'd0, swclk_o, swdio_o, swdio_oe}, 32'h7);
        check(busy === 1'b0, "R1 busy during reset", 32'(busy), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(swclk_o === 1'b1 && swdio_o === 1'b1 && swdio_oe === 1'b1 && busy === 1'b0,
              "R1 idle levels after reset", {28'd0, swclk_o, swdio_o, swdio_oe, busy}, 32'hE);
        check(idcode === 32'h0 && done === 1'b0, "R1 idcode and done at reset", idcode, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_tx(VEC[v][35:33], VEC[v][32:1], VEC[v][0]);
            ok_ack   = (VEC[v][35:33] == 3'b001);
            ones     = (VEC[v][32:1] == 32'hFFFFFFFF);
            exp_fail = !ok_ack || ones;
            if (!exp_fail) exp_id = VEC[v][32:1];
            check_wire(ok_ack);
            check(ack === VEC[v][35:33], "R6 ack capture", {29'd0, ack}, {29'd0, VEC[v][35:33]});
            check(fail === exp_fail, ok_ack ? "R8 fail on word" : "R7 fail on ack",
                  32'(fail), 32'(exp_fail));
            check(idcode === exp_id, exp_fail ? "R7 R8 idcode kept" : "R6 idcode captured",
                  idcode, exp_id);
            check(parity_ok === (!exp_fail && !VEC[v][0]), "R6 parity_ok",
                  32'(parity_ok), 32'(!exp_fail && !VEC[v][0]));
        end

        // Slower divider: period follows clk_div
        clk_div = 8'd3;
        run_tx(3'b001, 32'h4BA00477, 1'b0);
        check_wire(1'b1);
        check(idcode === 32'h4BA00477 && parity_ok === 1'b1, "R10 R6 read at divider 3",
              idcode, 32'h4BA00477);

        // Reset in the middle of a transaction returns the pads high
        clk_div = 8'd1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(swclk_o === 1'b1 && swdio_o === 1'b1 && swdio_oe === 1'b1 && busy === 1'b0,
              "R1 levels after reset mid-transaction", {28'd0, swclk_o, swdio_o, swdio_oe, busy}, 32'hE);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule